// File: doc/BRIEF.md
# Configuration Request PIO Engine

This block is a memory-mapped register file plus a small sequencer that lets a host processor push one PCIe configuration read or write at a time toward a completer. Software fills in a transaction kind, a dword-aligned configuration address, an upper address word, write data and a byte-enable mask. It then writes 1 to the start register. The engine copies those fields into a private request holder. It offers the request on a valid/ready request port and waits for a single completion beat on the completion port.

When the completion arrives, the engine records the outcome in the status register. That outcome is a 3-bit completion code, a non-posted flag and an error flag. A successful read also loads its data into the read-data register. At the same clock edge the start register reads back zero and the interrupt bit is set. The interrupt bit drives a level interrupt until software clears it with a write of one. A cycle-count watchdog closes a request that never completes and reports it as a completer abort with the error flag set.

The sequencer has three states. In IDLE nothing is outstanding. In ISSUE the request is offered and `req_valid` is high. In WAIT the request has been accepted and a completion is expected. The transitions are:
- launch: IDLE to ISSUE, on a start write while idle.
- accept: ISSUE to WAIT, when `req_ready` is high.
- issue-timeout: ISSUE to IDLE, when the watchdog expires before acceptance.
- complete: WAIT to IDLE, when `cpl_valid` is high.
- wait-timeout: WAIT to IDLE, when the watchdog expires with no completion.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `req_valid` is 0.
- R2: Register offsets are 0x00 control, 0x04 status, 0x08 address low, 0x0C address high, 0x10 write data, 0x14 byte mask, 0x18 read data, 0x1C start and 0x20 interrupt.
  - Control keeps only bits [3:0] (the kind) and bit 24 (window bypass). All other control bits read 0.
  - Address low reads back with bits [1:0] forced to 0.
  - The byte mask keeps bits [3:0].
  - Address high and write data read back as written.
- R3: A write with bit 0 set to the start register while idle launches a request. From the next cycle `req_valid` is 1 and the start register reads 1 until the request finishes.
- R4: Kind, both address words, write data and mask are captured at launch. Register writes made while the request is in flight do not change `req_*`.
- R5: A start write while a request is outstanding is ignored. No second request is issued.
- R6: `req_valid` stays high with stable fields until the cycle in which `req_ready` is high, or until the watchdog expires. A completion is taken only after the request has been accepted.
- R7: A completion updates the status register. Bits [9:7] take the completion code (0 success, 1 unsupported request, 2 retry, 4 completer abort). Bit 11 takes the error flag. Bit 10 is set when the kind is 0x8, 0x9, 0xA or 0xB (all non-posted). In the same edge start drops to 0 and interrupt bit 0 is set.
- R8: Read data is loaded only when the kind is 0x8 or 0x9, the code is 0 and the error flag is 0. Otherwise read data keeps its previous value.
- R9: If no completion has been taken within TIMEOUT_CYC cycles of launch, the request ends with status code 4 and error bit 11 set, and the interrupt bit is set. This counts acceptance and completion together.
- R10: `irq` follows interrupt bit 0. Writing 1 to bit 0 clears it and writing 0 has no effect. A completion in the same cycle wins over the clear.
- R11: The address-high word is forwarded on `req_addr_hi` unchanged, zero or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Completer accepts request |
| req_kind | output | 4 | Transaction kind |
| req_addr_lo | output | 32 | Configuration address |
| req_addr_hi | output | 32 | Upper address word |
| req_wdata | output | 32 | Write data |
| req_strb | output | 4 | Byte-enable mask |
| cpl_valid | input | 1 | Completion beat |
| cpl_code | input | 3 | Completion code |
| cpl_err | input | 1 | Completion error flag |
| cpl_data | input | 32 | Completion read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the engine with TIMEOUT_CYC set to 16 instead of the default 1024. With that setting, both timeout paths can be reached within a few dozen cycles. The bench exercises a completer that never accepts and a completer that accepts but never answers. With a short window, the watchdog's saturating count and its effect on status can be observed alongside normal completions that arrive several cycles after acceptance. A behavioural model runs in lockstep and checks `irq`, `req_valid` and the request fields on every clock.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;

    localparam int REG_AW = 6;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int KIND_W = 4;
    localparam int CODE_W = 3;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 6'h00;
    localparam logic [REG_AW-1:0] OFF_STAT  = 6'h04;
    localparam logic [REG_AW-1:0] OFF_ALO   = 6'h08;
    localparam logic [REG_AW-1:0] OFF_AHI   = 6'h0C;
    localparam logic [REG_AW-1:0] OFF_WDAT  = 6'h10;
    localparam logic [REG_AW-1:0] OFF_STRB  = 6'h14;
    localparam logic [REG_AW-1:0] OFF_RDAT  = 6'h18;
    localparam logic [REG_AW-1:0] OFF_START = 6'h1C;
    localparam logic [REG_AW-1:0] OFF_IRQ   = 6'h20;

    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0100_000F;

    localparam logic [CODE_W-1:0] CODE_OK    = 3'd0;
    localparam logic [CODE_W-1:0] CODE_ABORT = 3'd4;

    localparam logic [KIND_W-1:0] KIND_RD0 = 4'h8;
    localparam logic [KIND_W-1:0] KIND_RD1 = 4'h9;
    localparam logic [KIND_W-1:0] KIND_WR0 = 4'hA;
    localparam logic [KIND_W-1:0] KIND_WR1 = 4'hB;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [DATA_W-1:0] addr_lo;
        logic [DATA_W-1:0] addr_hi;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] strb;
    } pio_req_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              err;
        logic              nonposted;
        logic              load_rd;
        logic [DATA_W-1:0] data;
    } pio_result_t;

    function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
        return (k == KIND_RD0) || (k == KIND_RD1);
    endfunction

    function automatic logic kind_is_cfg(input logic [KIND_W-1:0] k);
        return kind_is_read(k) || (k == KIND_WR0) || (k == KIND_WR1);
    endfunction

endpackage

// File: rtl/cfg_pio_timer.sv
module cfg_pio_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // R9: the window count saturates at the last cycle of the window
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R9: a fresh run always begins with a zero count
    a_r9_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq import cfg_pio_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  pio_req_t          fields_i,
    input  logic              expired_i,
    input  logic              req_ready_i,
    input  logic              cpl_valid_i,
    input  logic [CODE_W-1:0] cpl_code_i,
    input  logic              cpl_err_i,
    input  logic [DATA_W-1:0] cpl_data_i,
    output logic              busy_o,
    output logic              req_valid_o,
    output pio_req_t          req_o,
    output logic              done_o,
    output pio_result_t       result_o
);
    seq_state_e state_q, state_d;
    pio_req_t   hold_q;
    logic       take_cpl;
    logic       take_tmo;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (launch_i) state_d = SEQ_ISSUE;
            SEQ_ISSUE: begin
                if (req_ready_i)    state_d = SEQ_WAIT;
                else if (expired_i) state_d = SEQ_IDLE;
            end
            SEQ_WAIT: begin
                if (cpl_valid_i)    state_d = SEQ_IDLE;
                else if (expired_i) state_d = SEQ_IDLE;
            end
            default:                state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // request holder, loaded only at launch
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (launch_i) hold_q <= fields_i;
    end

    // outputs
    always_comb begin
        busy_o      = 1'b0;
        req_valid_o = 1'b0;
        take_cpl    = 1'b0;
        take_tmo    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_ISSUE: begin
                busy_o      = 1'b1;
                req_valid_o = 1'b1;
                take_tmo    = !req_ready_i && expired_i;
            end
            SEQ_WAIT: begin
                busy_o   = 1'b1;
                take_cpl = cpl_valid_i;
                take_tmo = !cpl_valid_i && expired_i;
            end
            default: ;
        endcase
        done_o             = take_cpl || take_tmo;
        req_o              = hold_q;
        result_o.code      = take_cpl ? cpl_code_i : CODE_ABORT;
        result_o.err       = take_cpl ? cpl_err_i : 1'b1;
        result_o.nonposted = kind_is_cfg(hold_q.kind);
        result_o.load_rd   = take_cpl && kind_is_read(hold_q.kind)
                             && (cpl_code_i == CODE_OK) && !cpl_err_i;
        result_o.data      = cpl_data_i;
    end

    // R5: the register file only launches while the sequencer is idle
    a_r5_launch_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> (state_q == SEQ_IDLE));

    // R6: an offered request stays offered until taken or timed out
    a_r6_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && !expired_i) |=> req_valid_o);

    // R4: request fields hold while the offer is pending
    a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && !expired_i) |=> $stable(req_o));

    // R7: finishing a request returns the sequencer to idle
    a_r7_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs import cfg_pio_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy_i,
    output logic              launch_o,
    output pio_req_t          fields_o,
    input  logic              done_i,
    input  pio_result_t       result_i,
    output logic              irq_o
);
    localparam int STAT_PAD = DATA_W - 12;

    logic [DATA_W-1:0] ctrl_q, alo_q, ahi_q, wdat_q, rdat_q, stat_q;
    logic [STRB_W-1:0] strb_q;
    logic              irq_q;
    logic              wr_ctrl, wr_alo, wr_ahi, wr_wdat, wr_strb, wr_start, wr_irq;

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
        wr_alo   = bus_wr && (bus_addr == OFF_ALO);
        wr_ahi   = bus_wr && (bus_addr == OFF_AHI);
        wr_wdat  = bus_wr && (bus_addr == OFF_WDAT);
        wr_strb  = bus_wr && (bus_addr == OFF_STRB);
        wr_start = bus_wr && (bus_addr == OFF_START);
        wr_irq   = bus_wr && (bus_addr == OFF_IRQ);
        launch_o = wr_start && bus_wdata[0] && !busy_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
            wdat_q <= '0;
            strb_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (wr_alo)  alo_q  <= {bus_wdata[DATA_W-1:2], 2'b00};
            if (wr_ahi)  ahi_q  <= bus_wdata;
            if (wr_wdat) wdat_q <= bus_wdata;
            if (wr_strb) strb_q <= bus_wdata[STRB_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            rdat_q <= '0;
        end else if (done_i) begin
            stat_q <= {{STAT_PAD{1'b0}}, result_i.err, result_i.nonposted,
                       result_i.code, 7'b0};
            if (result_i.load_rd) rdat_q <= result_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     irq_q <= 1'b0;
        else if (done_i)                irq_q <= 1'b1;
        else if (wr_irq && bus_wdata[0]) irq_q <= 1'b0;
    end

    always_comb begin
        fields_o.kind    = ctrl_q[KIND_W-1:0];
        fields_o.addr_lo = alo_q;
        fields_o.addr_hi = ahi_q;
        fields_o.wdata   = wdat_q;
        fields_o.strb    = strb_q;
        irq_o            = irq_q;
    end

    always_comb begin
        case (bus_addr)
            OFF_CTRL:  bus_rdata = ctrl_q;
            OFF_STAT:  bus_rdata = stat_q;
            OFF_ALO:   bus_rdata = alo_q;
            OFF_AHI:   bus_rdata = ahi_q;
            OFF_WDAT:  bus_rdata = wdat_q;
            OFF_STRB:  bus_rdata = {{(DATA_W-STRB_W){1'b0}}, strb_q};
            OFF_RDAT:  bus_rdata = rdat_q;
            OFF_START: bus_rdata = {{(DATA_W-1){1'b0}}, busy_i};
            OFF_IRQ:   bus_rdata = {{(DATA_W-1){1'b0}}, irq_q};
            default:   bus_rdata = '0;
        endcase
    end

    // R10: a finished request always leaves the interrupt raised
    a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> irq_q);

    // R8: outcomes that are not clean reads leave read data alone
    a_r8_rd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !result_i.load_rd) |=> $stable(rdat_q));

    // R7: status only moves when a request finishes
    a_r7_stat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(stat_q));

endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine import cfg_pio_pkg::*; #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [KIND_W-1:0] req_kind,
    output logic [DATA_W-1:0] req_addr_lo,
    output logic [DATA_W-1:0] req_addr_hi,
    output logic [DATA_W-1:0] req_wdata,
    output logic [STRB_W-1:0] req_strb,
    input  logic              cpl_valid,
    input  logic [CODE_W-1:0] cpl_code,
    input  logic              cpl_err,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              irq
);
    logic        busy, launch, done, expired;
    pio_req_t    fields, req;
    pio_result_t result;

    cfg_pio_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy_i    (busy),
        .launch_o  (launch),
        .fields_o  (fields),
        .done_i    (done),
        .result_i  (result),
        .irq_o     (irq)
    );

    cfg_pio_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .fields_i    (fields),
        .expired_i   (expired),
        .req_ready_i (req_ready),
        .cpl_valid_i (cpl_valid),
        .cpl_code_i  (cpl_code),
        .cpl_err_i   (cpl_err),
        .cpl_data_i  (cpl_data),
        .busy_o      (busy),
        .req_valid_o (req_valid),
        .req_o       (req),
        .done_o      (done),
        .result_o    (result)
    );

    cfg_pio_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .expired_o (expired)
    );

    assign req_kind    = req.kind;
    assign req_addr_lo = req.addr_lo;
    assign req_addr_hi = req.addr_hi;
    assign req_wdata   = req.wdata;
    assign req_strb    = req.strb;

    // R11: the upper word leaves the block exactly as it was captured
    a_r11_hi_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy) |=> (req_addr_hi == $past(fields.addr_hi)));

endmodule

// File: tb/cfg_pio_engine_bench.sv
module cfg_pio_engine_bench;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [3:0]  req_kind;
    logic [31:0] req_addr_lo, req_addr_hi, req_wdata;
    logic [3:0]  req_strb;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_code = '0;
    logic        cpl_err = 1'b0;
    logic [31:0] cpl_data = '0;
    logic        irq;

    cfg_pio_engine #(.TIMEOUT_CYC(TMO)) u_cfg_pio_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_kind(req_kind), .req_addr_lo(req_addr_lo),
        .req_addr_hi(req_addr_hi), .req_wdata(req_wdata), .req_strb(req_strb),
        .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_err(cpl_err),
        .cpl_data(cpl_data), .irq(irq)
    );

    always #4 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state
    int          m_phase = 0;   // 0 idle, 1 offered, 2 accepted
    int          m_tcnt = 0, m_icnt = 0, m_wcnt = 0;
    logic [31:0] m_ctrl = 0, m_stat = 0, m_alo = 0, m_ahi = 0, m_wd = 0, m_rd = 0;
    logic [3:0]  m_strb = 0;
    logic        m_irq = 0;
    logic [3:0]  s_kind = 0;
    logic [31:0] s_alo = 0, s_ahi = 0, s_wd = 0;
    logic [3:0]  s_strb = 0;

    // behavioural completer settings (-1 means never)
    int          cp_rdy = 0, cp_cpl = 0;
    logic [2:0]  cp_code = 0;
    logic        cp_err = 0;
    logic [31:0] cp_data = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_addr(int b, int d, int f, int r);
        return ((b & 255) << 20) | ((d & 31) << 15) | ((f & 7) << 12) | (r & 'hffc);
    endfunction

    function automatic logic [3:0] strobe(int bytes, int off);
        return 4'(((1 << bytes) - 1) << (off & 3));
    endfunction

    task automatic step();
        int nphase;
        bit rdy, cv, expd, done, cfgk, rdk;
        logic [2:0] code;
        logic err;
        rdy = (m_phase == 1) && (cp_rdy >= 0) && (m_icnt >= cp_rdy);
        cv  = (m_phase == 2) && (cp_cpl >= 0) && (m_wcnt >= cp_cpl);
        req_ready = rdy; cpl_valid = cv; cpl_code = cp_code;
        cpl_err = cp_err; cpl_data = cp_data;
        expd = (m_phase != 0) && (m_tcnt == TMO - 1);
        nphase = m_phase; done = 0;
        if (m_phase == 1) begin
            if (rdy) nphase = 2; else if (expd) begin nphase = 0; done = 1; end
        end else if (m_phase == 2) begin
            if (cv || expd) begin nphase = 0; done = 1; end
        end
        @(posedge clk);
        if (done) begin
            code = cv ? cp_code : 3'd4;
            err  = cv ? cp_err : 1'b1;
            cfgk = (s_kind >= 8) && (s_kind <= 11);
            rdk  = (s_kind == 8) || (s_kind == 9);
            m_stat = (32'(err) << 11) | (32'(cfgk) << 10) | (32'(code) << 7);
            if (rdk && cv && code == 0 && !err) m_rd = cp_data;
        end
        if (bus_wr) begin
            case (bus_addr)
                6'h00: m_ctrl = bus_wdata & 32'h0100000F;
                6'h08: m_alo  = bus_wdata & 32'hFFFFFFFC;
                6'h0C: m_ahi  = bus_wdata;
                6'h10: m_wd   = bus_wdata;
                6'h14: m_strb = bus_wdata[3:0];
                default: ;
            endcase
        end
        if (done) m_irq = 1;
        else if (bus_wr && bus_addr == 6'h20 && bus_wdata[0]) m_irq = 0;
        m_tcnt = (m_phase == 0) ? 0 : ((m_tcnt < TMO - 1) ? m_tcnt + 1 : m_tcnt);
        m_icnt = (m_phase == 1 && nphase == 1) ? m_icnt + 1 : 0;
        m_wcnt = (m_phase == 2 && nphase == 2) ? m_wcnt + 1 : 0;
        if (m_phase == 0 && bus_wr && bus_addr == 6'h1C && bus_wdata[0]) begin
            nphase = 1;
            s_kind = m_ctrl[3:0]; s_alo = m_alo; s_ahi = m_ahi;
            s_wd = m_wd; s_strb = m_strb;
        end
        m_phase = nphase;
        @(negedge clk);
        req_ready = 0; cpl_valid = 0;
        check("R10 irq level", {31'b0, irq}, {31'b0, m_irq});
        check("R6 req_valid", {31'b0, req_valid}, {31'b0, m_phase == 1});
        if (m_phase == 1) begin
            check("R4 req_kind", {28'b0, req_kind}, {28'b0, s_kind});
            check("R4 req_addr_lo", req_addr_lo, s_alo);
            check("R11 req_addr_hi", req_addr_hi, s_ahi);
            check("R4 req_wdata", req_wdata, s_wd);
            check("R4 req_strb", {28'b0, req_strb}, {28'b0, s_strb});
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0;
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 100 && !m_irq; i++) step();
    endtask

    task automatic run_req(input logic [3:0] kind, input logic [31:0] alo,
                           input logic [3:0] strb, input logic [31:0] wd);
        wr(6'h20, 1);
        wr(6'h00, {28'b0, kind});
        wr(6'h08, alo);
        wr(6'h14, {28'b0, strb});
        wr(6'h10, wd);
        wr(6'h1C, 1);
        wait_done();
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        rd("R1 ctrl", 6'h00, 0); rd("R1 stat", 6'h04, 0); rd("R1 rdat", 6'h18, 0);
        rd("R1 start", 6'h1C, 0); rd("R1 irq reg", 6'h20, 0);
        check("R1 irq pin", {31'b0, irq}, 0);
        check("R1 req_valid", {31'b0, req_valid}, 0);

        // R2 map and masks
        wr(6'h00, 32'hFFFF_FFFF); rd("R2 ctrl mask", 6'h00, 32'h0100_000F);
        wr(6'h08, 32'hFFFF_FFFF); rd("R2 alo low bits", 6'h08, 32'hFFFF_FFFC);
        wr(6'h14, 32'h0000_00FF); rd("R2 strobe width", 6'h14, 32'hF);
        wr(6'h0C, 32'h1234_5678); rd("R2 ahi", 6'h0C, 32'h1234_5678);
        wr(6'h10, 32'hA5A5_5A5A); rd("R2 wdata", 6'h10, 32'hA5A5_5A5A);
        wr(6'h0C, 0);

        // R3 R4 R5 R6 R7 R8: clean type-0 read with delayed completer
        cp_rdy = 2; cp_cpl = 3; cp_code = 0; cp_err = 0; cp_data = 32'hCAFE_F00D;
        wr(6'h00, 32'h8);
        wr(6'h08, cfg_addr(0, 0, 0, 'h10));
        wr(6'h14, strobe(4, 'h10));
        wr(6'h1C, 1);
        rd("R3 start busy", 6'h1C, 1);
        check("R6 offered", {31'b0, req_valid}, 1);
        wr(6'h08, 32'h0000_0123);            // R4 in-flight change
        rd("R2 alo readback", 6'h08, 32'h0000_0120);
        wr(6'h1C, 1);                        // R5 ignored while busy
        wait_done();
        rd("R7 stat ok read", 6'h04, 32'h0000_0400);
        rd("R8 rdata loaded", 6'h18, 32'hCAFE_F00D);
        rd("R7 start cleared", 6'h1C, 0);
        rd("R7 irq set", 6'h20, 1);
        repeat (3) step();
        check("R5 no second request", {31'b0, req_valid}, 0);

        // R10 write-one-to-clear
        wr(6'h20, 0); rd("R10 zero no effect", 6'h20, 1);
        wr(6'h20, 1); rd("R10 one clears", 6'h20, 0);
        check("R10 irq pin low", {31'b0, irq}, 0);

        // R7 R8 type-0 write, unsupported request
        cp_rdy = 0; cp_cpl = 1; cp_code = 1; cp_err = 0; cp_data = 32'h1111_1111;
        run_req(4'hA, cfg_addr(0, 0, 1, 'h06), strobe(2, 'h06), 32'hBEEF_0000);
        rd("R7 stat UR write", 6'h04, 32'h0000_0480);
        rd("R8 rdata kept UR", 6'h18, 32'hCAFE_F00D);

        // R8 type-1 read, retry code, with address high nonzero (R11)
        wr(6'h0C, 32'h0000_00AB);
        cp_rdy = 1; cp_cpl = 0; cp_code = 2; cp_data = 32'h2222_2222;
        run_req(4'h9, cfg_addr(3, 4, 2, 'h40), 4'hF, 0);
        rd("R7 stat CRS", 6'h04, 32'h0000_0500);
        rd("R8 rdata kept CRS", 6'h18, 32'hCAFE_F00D);
        rd("R11 ahi kept", 6'h0C, 32'h0000_00AB);
        wr(6'h0C, 0);

        // R8 success code but error flag
        cp_rdy = 0; cp_cpl = 2; cp_code = 0; cp_err = 1; cp_data = 32'h3333_3333;
        run_req(4'h8, cfg_addr(0, 0, 0, 'h00), 4'hF, 0);
        rd("R7 stat err flag", 6'h04, 32'h0000_0C00);
        rd("R8 rdata kept err", 6'h18, 32'hCAFE_F00D);

        // R7 non-configuration kind: no non-posted flag
        cp_err = 0; cp_code = 0; cp_data = 32'h4444_4444;
        run_req(4'h0, 32'h0000_0100, 4'h1, 32'h55);
        rd("R7 stat posted kind", 6'h04, 32'h0000_0000);
        rd("R8 rdata kept non-read", 6'h18, 32'hCAFE_F00D);

        // R9 accepted but never completed
        cp_rdy = 0; cp_cpl = -1; cp_data = 32'h5555_5555;
        run_req(4'h8, cfg_addr(1, 2, 3, 'h08), 4'hF, 0);
        rd("R9 stat wait timeout", 6'h04, 32'h0000_0E00);
        rd("R9 start cleared", 6'h1C, 0);
        rd("R9 irq raised", 6'h20, 1);

        // R9 never accepted
        cp_rdy = -1; cp_cpl = 0;
        run_req(4'hB, cfg_addr(1, 0, 0, 'h0C), 4'hF, 32'h77);
        rd("R9 stat issue timeout", 6'h04, 32'h0000_0E00);
        rd("R8 rdata kept timeout", 6'h18, 32'hCAFE_F00D);

        // R8 second clean read, type 1
        cp_rdy = 0; cp_cpl = 0; cp_code = 0; cp_data = 32'h0BAD_CAFE;
        run_req(4'h9, cfg_addr(2, 0, 0, 'h04), 4'hF, 0);
        rd("R8 rdata loaded type1", 6'h18, 32'h0BAD_CAFE);
        repeat (2) step();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule